// File: doc/BRIEF.md
# Reduced Boundary-Scan Test Access Port Controller

This block is the serial test port of a memory device. A tester drives a test clock, a mode-select line and a serial data input. The block walks the standard sixteen-state test port state machine, keeps a 3-bit instruction, and connects one of three data registers between the serial input and the serial output. The three data registers are a 1-bit bypass stage, a fixed 32-bit identification word, and a boundary register that loads the memory pin levels in parallel.

The instruction set is reduced. There is an external-test code, an identification code, a sample-with-outputs-off code, a plain sample code and a bypass code. The sample code has no preload step. The boundary register never drives the pins, so the only effect the block has on the memory is one request line that puts the memory outputs into high impedance. Shifting is least-significant bit first. The serial output is re-timed onto the falling test-clock edge, and an enable for the serial output driver comes with it.

Top module: `scan_tap`

## Requirements
- R1: While `rst_n` is low on a rising `tck` edge, the controller goes to Test-Logic-Reset and the instruction becomes IDCODE (001). Before the first shift, `tdo_en` and `pins_hiz` are both 0.
- R2: From any state, five rising `tck` edges with `tms` high reach Test-Logic-Reset. The next rising edge with `tms` low enters Run-Test/Idle with the instruction set back to IDCODE. An instruction that was partly shifted is discarded.
- R3: `tms` and `tdi` are sampled on the rising edge of `tck`. `tdo` changes only on the falling edge, so across a rising edge it keeps the bit the tester is sampling.
- R4: Capture-IR loads the pattern 001 into the instruction shift stage. Shift-IR then outputs 1, 0, 0 on `tdo`.
- R5: Under IDCODE (001), Capture-DR loads a 32-bit word: revision in bits 31:28, depth in 27:23, width in 22:18, device code in 17:12, manufacturer code in 11:1, and bit 0 fixed at 1. With the default parameters the word is 0x288A_B78D.
- R6: Under BYPASS (111), a single stage sits between `tdi` and `tdo`. This stage captures 0, so the first bit out is 0 and every later bit is the `tdi` bit from one shift earlier.
- R7: The reserved codes 011, 101 and 110 select the bypass stage and leave `pins_hiz` low.
- R8: Under EXTEST (000), Capture-DR loads `pin_cap` into the boundary register, Shift-DR outputs it bit 0 first, and `pins_hiz` is 1.
- R9: Under SAMPLE-Z (010), the boundary register is captured and shifted the same way as under EXTEST, and `pins_hiz` is 1.
- R10: Under SAMPLE (100), the boundary register is captured and shifted with `pins_hiz` at 0. Data shifted in is not applied anywhere, so the next capture again returns the current `pin_cap`.
- R11: `tdo_en` is 1 only while the controller is in Shift-IR or Shift-DR. It follows the state on the falling edge.
- R12: A new instruction takes effect only on the rising edge that leaves Update-IR. `pins_hiz` does not change during Shift-IR, Exit1-IR or Update-IR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Power-up reset, active low, sampled on tck edges |
| tms | input | 1 | Mode select that steers the state machine |
| tdi | input | 1 | Serial data into the selected register |
| pin_cap | input | BSR_LEN (68) | Memory pin levels captured by the boundary register |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_en | output | 1 | Output driver enable for tdo |
| pins_hiz | output | 1 | Request that forces the memory outputs to high impedance |

## Verification
The bench uses a scoreboard to compare every serially shifted bit. It goes after these corner cases:
- Escape from Shift-DR and from Shift-IR with five high `tms` clocks. A design that keeps a partly shifted instruction, or keeps EXTEST after the escape, would return the wrong word or leave `pins_hiz` high.
- The exact cycle in which `pins_hiz` rises. A design that decoded the shift stage instead of the updated instruction would raise it early, during Exit1-IR or Update-IR.
- Reserved codes. A wrong decode would hand out identification or boundary bits instead of the delayed `tdi` stream.
- Recapture under SAMPLE, which catches a design that recirculates the shifted data.
- Sampling `tdo` on both sides of a rising edge, which exposes a design that retimes `tdo` on the wrong edge.

// File: rtl/scan_tap_pkg.sv
// Shared types for the test access port: state encoding, instruction
// codes and data-register selection. Assumes a 3-bit instruction.
package scan_tap_pkg;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_IDLE,
        ST_SEL_DR,
        ST_CAP_DR,
        ST_SH_DR,
        ST_EX1_DR,
        ST_PAU_DR,
        ST_EX2_DR,
        ST_UPD_DR,
        ST_SEL_IR,
        ST_CAP_IR,
        ST_SH_IR,
        ST_EX1_IR,
        ST_PAU_IR,
        ST_EX2_IR,
        ST_UPD_IR
    } tap_state_t;

    localparam int unsigned IR_W = 3;
    typedef logic [IR_W-1:0] ir_code_t;

    localparam ir_code_t OP_EXTEST  = 3'b000;
    localparam ir_code_t OP_IDCODE  = 3'b001;
    localparam ir_code_t OP_SAMPLEZ = 3'b010;
    localparam ir_code_t OP_SAMPLE  = 3'b100;
    localparam ir_code_t OP_BYPASS  = 3'b111;
    localparam ir_code_t IR_CAPTURE = 3'b001;

    typedef enum logic [1:0] {
        DR_BYPASS,
        DR_IDENT,
        DR_BOUNDARY
    } dr_sel_t;

endpackage

// File: rtl/scan_tap_fsm.sv
// Sixteen-state test port sequencer driven by tms on rising tck.
// Assumes rst_n is synchronous and active low; reset enters ST_RESET.
module scan_tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_t state_q
);

    tap_state_t state_d;

    // Next-state selection from the current state and tms.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET:  state_d = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   state_d = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: state_d = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_IDLE;
            default:   state_d = ST_RESET;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge tck) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/scan_tap_ir.sv
// Instruction register: a shift stage plus an update stage.
// Assumes the update stage loads on the edge leaving Update-IR and
// returns to IDCODE on the edge leaving Test-Logic-Reset.
module scan_tap_ir
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tdi,
    input  tap_state_t state,
    output ir_code_t   ir_q,
    output logic       ir_lsb
);

    ir_code_t sh_q;

    // Shift stage: capture the fixed pattern, then shift toward bit 0.
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            sh_q <= IR_CAPTURE;
        end else if (state == ST_CAP_IR) begin
            sh_q <= IR_CAPTURE;
        end else if (state == ST_SH_IR) begin
            sh_q <= {tdi, sh_q[IR_W-1:1]};
        end
    end

    // Update stage: the instruction that drives decode.
    always_ff @(posedge tck) begin
        if (!rst_n || state == ST_RESET) ir_q <= OP_IDCODE;
        else if (state == ST_UPD_IR)     ir_q <= sh_q;
    end

    assign ir_lsb = sh_q[0];

endmodule

// File: rtl/scan_tap_dr.sv
// Data registers: bypass stage, identification word and boundary
// register with parallel capture. Assumes only the selected register
// captures or shifts; the others hold their contents.
module scan_tap_dr
    import scan_tap_pkg::*;
#(
    parameter int unsigned BSR_LEN = 68,
    parameter int unsigned ID_W    = 32,
    parameter logic [ID_W-1:0] ID_WORD = '1
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               tdi,
    input  tap_state_t         state,
    input  ir_code_t           ir,
    input  logic [BSR_LEN-1:0] pin_cap,
    output logic               dr_lsb
);

    dr_sel_t            sel;
    logic               byp_q;
    logic [ID_W-1:0]    id_q;
    logic [BSR_LEN-1:0] bsr_q;

    // Decode the instruction to a data register; unlisted codes bypass.
    always_comb begin
        unique case (ir)
            OP_EXTEST, OP_SAMPLEZ, OP_SAMPLE: sel = DR_BOUNDARY;
            OP_IDCODE:                        sel = DR_IDENT;
            default:                          sel = DR_BYPASS;
        endcase
    end

    // Bypass stage: captures 0, shifts tdi.
    always_ff @(posedge tck) begin
        if (!rst_n)                                        byp_q <= 1'b0;
        else if (sel == DR_BYPASS && state == ST_CAP_DR)   byp_q <= 1'b0;
        else if (sel == DR_BYPASS && state == ST_SH_DR)    byp_q <= tdi;
    end

    // Identification register: loads the fixed word, shifts toward bit 0.
    always_ff @(posedge tck) begin
        if (!rst_n)                                        id_q <= ID_WORD;
        else if (sel == DR_IDENT && state == ST_CAP_DR)    id_q <= ID_WORD;
        else if (sel == DR_IDENT && state == ST_SH_DR)     id_q <= {tdi, id_q[ID_W-1:1]};
    end

    // Boundary register: parallel capture of the pins, serial shift.
    always_ff @(posedge tck) begin
        if (!rst_n)                                        bsr_q <= '0;
        else if (sel == DR_BOUNDARY && state == ST_CAP_DR) bsr_q <= pin_cap;
        else if (sel == DR_BOUNDARY && state == ST_SH_DR)  bsr_q <= {tdi, bsr_q[BSR_LEN-1:1]};
    end

    // Serial output of the selected register.
    always_comb begin
        unique case (sel)
            DR_IDENT:    dr_lsb = id_q[0];
            DR_BOUNDARY: dr_lsb = bsr_q[0];
            default:     dr_lsb = byp_q;
        endcase
    end

endmodule

// File: rtl/scan_tap.sv
// Top of the reduced test access port. Assumes the tester samples tdo
// on rising tck; tdo and tdo_en are retimed to the falling edge.
module scan_tap
    import scan_tap_pkg::*;
#(
    parameter int unsigned BSR_LEN  = 68,
    parameter logic [3:0]  ID_REV   = 4'h2,
    parameter logic [4:0]  ID_DEPTH = 5'h11,
    parameter logic [4:0]  ID_WIDTH = 5'h02,
    parameter logic [5:0]  ID_DEV   = 6'h2B,
    parameter logic [10:0] ID_MFR   = 11'h3C6
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pin_cap,
    output logic               tdo,
    output logic               tdo_en,
    output logic               pins_hiz
);

    localparam int unsigned ID_W = 32;
    localparam logic [ID_W-1:0] ID_WORD =
        {ID_REV, ID_DEPTH, ID_WIDTH, ID_DEV, ID_MFR, 1'b1};

    tap_state_t state;
    ir_code_t   ir_q;
    logic       ir_lsb;
    logic       dr_lsb;
    logic       in_shift;

    scan_tap_fsm u_fsm (
        .tck     (tck),
        .rst_n   (rst_n),
        .tms     (tms),
        .state_q (state)
    );

    scan_tap_ir u_ir (
        .tck    (tck),
        .rst_n  (rst_n),
        .tdi    (tdi),
        .state  (state),
        .ir_q   (ir_q),
        .ir_lsb (ir_lsb)
    );

    scan_tap_dr #(
        .BSR_LEN (BSR_LEN),
        .ID_W    (ID_W),
        .ID_WORD (ID_WORD)
    ) u_dr (
        .tck     (tck),
        .rst_n   (rst_n),
        .tdi     (tdi),
        .state   (state),
        .ir      (ir_q),
        .pin_cap (pin_cap),
        .dr_lsb  (dr_lsb)
    );

    assign in_shift = (state == ST_SH_IR) || (state == ST_SH_DR);

    // Falling-edge retiming of the serial output and its enable.
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= in_shift;
            tdo    <= (state == ST_SH_IR) ? ir_lsb : dr_lsb;
        end
    end

    // Output-disable request for the two isolating instructions.
    assign pins_hiz = (ir_q == OP_EXTEST) || (ir_q == OP_SAMPLEZ);

endmodule

// File: rtl/scan_tap_chk.sv
// Checker for scan_tap, bound to the top. Assumes rst_n low for at
// least one falling and one rising edge at start-up.
module scan_tap_chk
    import scan_tap_pkg::*;
(
    input logic       tck,
    input logic       rst_n,
    input logic       tms,
    input tap_state_t state,
    input ir_code_t   ir,
    input logic       tdo_en,
    input logic       pins_hiz
);

    logic [2:0] hi_cnt;

    // Count consecutive tms-high edges, saturating at five.
    always_ff @(posedge tck) begin
        if (!rst_n || !tms)   hi_cnt <= 3'd0;
        else if (hi_cnt != 3'd5) hi_cnt <= hi_cnt + 3'd1;
    end

    AST_FIVE_HIGH_RESETS: assert property (@(posedge tck) disable iff (!rst_n)
        (hi_cnt == 3'd5) |-> (state == ST_RESET)); // R2

    AST_RESET_LOADS_IDCODE: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_RESET) |=> (ir == OP_IDCODE)); // R1

    AST_TDOEN_ONLY_SHIFT: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_en |-> (state == ST_SH_IR || state == ST_SH_DR)); // R11

    AST_IR_CHANGES_ON_UPDATE: assert property (@(posedge tck) disable iff (!rst_n)
        !$stable(ir) |-> ($past(state) == ST_UPD_IR || $past(state) == ST_RESET)); // R12

    AST_HIZ_RISES_ON_UPDATE: assert property (@(posedge tck) disable iff (!rst_n)
        $rose(pins_hiz) |-> ($past(state) == ST_UPD_IR)); // R12

endmodule

bind scan_tap scan_tap_chk u_chk (
    .tck      (tck),
    .rst_n    (rst_n),
    .tms      (tms),
    .state    (state),
    .ir       (ir_q),
    .tdo_en   (tdo_en),
    .pins_hiz (pins_hiz)
);

// File: tb/tb_scan_tap.sv
// Scoreboard bench for scan_tap: shift tasks queue expected bits, a
// monitor compares them with the bits seen on tdo.
module tb_scan_tap;

    localparam int N = 68;
    localparam logic [31:0] EXP_ID = {4'h2, 5'h11, 5'h02, 6'h2B, 11'h3C6, 1'b1};

    logic         tck = 1'b0;
    logic         rst_n = 1'b0;
    logic         tms = 1'b1;
    logic         tdi = 1'b0;
    logic [N-1:0] pin_cap = '0;
    logic         tdo, tdo_en, pins_hiz;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    logic  exp_bits[$];
    string exp_tags[$];
    logic  act_bits[$];

    always #4 tck = ~tck;

    scan_tap dut (
        .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi),
        .pin_cap(pin_cap), .tdo(tdo), .tdo_en(tdo_en), .pins_hiz(pins_hiz)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pop and compare each scoreboard pair.
    always @(posedge tck) begin
        logic  e, a;
        string t;
        while (exp_bits.size() > 0 && act_bits.size() > 0) begin
            e = exp_bits.pop_front();
            t = exp_tags.pop_front();
            a = act_bits.pop_front();
            check(a === e, t, {127'b0, a}, {127'b0, e});
        end
    end

    task automatic tick(input logic m, input logic d);
        @(negedge tck); #1;
        tms = m; tdi = d;
        @(posedge tck); #1;
    endtask

    task automatic tick_o(input logic m, input logic d, output logic o);
        @(negedge tck); #1;
        o = tdo;
        tms = m; tdi = d;
        @(posedge tck); #1;
    endtask

    task automatic tap_reset();
        repeat (5) tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
    endtask

    // From Run-Test/Idle: load an instruction, expect the 001 capture (R4).
    task automatic load_ir(input logic [2:0] code);
        logic o;
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 3; i++) begin
            tick_o(i == 2, code[i], o);
            exp_bits.push_back(3'b001 >> i);
            exp_tags.push_back("R4");
            act_bits.push_back(o);
        end
        tick(1, 0); tick(0, 0);
    endtask

    // From Run-Test/Idle: capture and shift n bits of the selected register.
    task automatic scan_dr(input int n, input logic [127:0] din,
                           input logic [127:0] exp, input string tag);
        logic o;
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < n; i++) begin
            tick_o(i == n - 1, din[i], o);
            exp_bits.push_back(exp[i]);
            exp_tags.push_back(tag);
            act_bits.push_back(o);
        end
        tick(1, 0); tick(0, 0);
    endtask

    initial begin
        logic a, b, c;
        logic [N-1:0] pa, pb, pc, pd;
        pa = {4'hA, 64'h0123_4567_89AB_CDEF};
        pb = {4'h5, 64'hFEDC_BA98_7654_3210};
        pc = {4'h3, 64'h8000_0000_0000_0001};
        pd = {4'hC, 64'h5A5A_A5A5_0F0F_F0F0};

        repeat (3) @(posedge tck);
        #1;
        check(tdo_en == 1'b0, "R1 tdo_en in reset", {127'b0, tdo_en}, 0);
        check(pins_hiz == 1'b0, "R1 pins_hiz in reset", {127'b0, pins_hiz}, 0);
        @(negedge tck); #1; rst_n = 1'b1;
        tick(0, 0);
        check(tdo_en == 1'b0, "R11 idle tdo_en", {127'b0, tdo_en}, 0);
        scan_dr(32, '0, {96'b0, EXP_ID}, "R1 R5 idcode after reset");

        // R3 and R11: tdo holds across the rising edge, moves on falling.
        tick(1, 0); tick(0, 0); tick(0, 0);
        @(negedge tck); #1; a = tdo;
        check(tdo_en == 1'b1, "R11 shift tdo_en", {127'b0, tdo_en}, 1);
        tms = 0; tdi = 0;
        @(posedge tck); #1; b = tdo;
        check(b === a, "R3 hold across rise", {127'b0, b}, {127'b0, a});
        @(negedge tck); #1; c = tdo;
        check(c === EXP_ID[1], "R3 change on fall", {127'b0, c}, {127'b0, EXP_ID[1]});
        tms = 1;
        @(posedge tck); #1;
        tick(1, 0); tick(0, 0);

        // R12: EXTEST only takes hold after Update-IR.
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        tick(0, 0); tick(0, 0); tick(1, 0);
        check(pins_hiz == 1'b0, "R12 hiz in exit1", {127'b0, pins_hiz}, 0);
        tick(1, 0);
        check(pins_hiz == 1'b0, "R12 hiz in update", {127'b0, pins_hiz}, 0);
        tick(0, 0);
        check(pins_hiz == 1'b1, "R12 hiz after update", {127'b0, pins_hiz}, 1);

        // R8: EXTEST captures the pins.
        pin_cap = pa;
        scan_dr(N, '0, {60'b0, pa}, "R8 extest capture");
        check(pins_hiz == 1'b1, "R8 hiz", {127'b0, pins_hiz}, 1);

        // R2: escape from Shift-DR under EXTEST.
        tick(1, 0); tick(0, 0); tick(0, 0); tick(0, 1);
        repeat (5) tick(1, 0);
        tick(0, 0);
        check(pins_hiz == 1'b0, "R2 hiz cleared", {127'b0, pins_hiz}, 0);
        scan_dr(32, '0, {96'b0, EXP_ID}, "R2 idcode after escape");

        // R2: escape from Shift-IR with a partial BYPASS code.
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        tick(0, 1); tick(0, 1);
        repeat (5) tick(1, 1);
        tick(0, 0);
        scan_dr(32, '0, {96'b0, EXP_ID}, "R2 idcode after ir escape");

        // R9: SAMPLE-Z.
        load_ir(3'b010);
        pin_cap = pb;
        scan_dr(N, '0, {60'b0, pb}, "R9 samplez capture");
        check(pins_hiz == 1'b1, "R9 hiz", {127'b0, pins_hiz}, 1);

        // R10: SAMPLE, no output disable, recapture ignores shifted data.
        load_ir(3'b100);
        check(pins_hiz == 1'b0, "R10 hiz", {127'b0, pins_hiz}, 0);
        pin_cap = pc;
        scan_dr(N, {60'b0, ~pc}, {60'b0, pc}, "R10 sample capture");
        pin_cap = pd;
        scan_dr(N, '0, {60'b0, pd}, "R10 sample recapture");

        // R6: BYPASS captures 0 and delays tdi by one stage.
        load_ir(3'b111);
        scan_dr(5, 128'b10010, 128'b00100, "R6 bypass");

        // R7: reserved codes behave as bypass.
        load_ir(3'b011);
        scan_dr(4, 128'b1011, 128'b0110, "R7 reserved 011");
        check(pins_hiz == 1'b0, "R7 hiz", {127'b0, pins_hiz}, 0);
        load_ir(3'b101);
        scan_dr(4, 128'b0111, 128'b1110, "R7 reserved 101");
        load_ir(3'b110);
        scan_dr(4, 128'b1101, 128'b1010, "R7 reserved 110");

        // R5: explicit IDCODE load.
        load_ir(3'b001);
        scan_dr(32, '1, {96'b0, EXP_ID}, "R5 idcode explicit");

        repeat (3) @(posedge tck);
        #1;
        check(exp_bits.size() == 0 && act_bits.size() == 0, "R4 scoreboard drained",
              {96'b0, 32'(act_bits.size())}, {96'b0, 32'(exp_bits.size())});
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule